// File: doc/BRIEF.md
# Write Status Polling Responder

This block forms the byte returned to a host read while a nonvolatile write or erase is running inside the memory. While the busy flag is high, a read does not return stored data. It returns two completion indicators. Bit 7 holds the inverse of bit 7 of the most recently loaded byte. Bit 6 flips on every read and starts at 1 for each new busy period. The host polls either bit until the true value appears or the flipping stops.

When the busy flag drops, a short settling window follows. The length of this window is a parameter in cycles. Inside the window, bits 7 and 6 already carry true array data, and bits 5..0 carry a fixed fill pattern. After the window, reads pass array data through unchanged. During an erase, only the flipping bit carries meaning. Bit 7 then reads 0, because an erased byte is all ones and its inverse is 0.

Each read strobe produces one registered result one cycle later, marked by a one-cycle valid pulse.

Top module: `wsp_status_responder`

## Requirements
- R1: After reset, `rd_valid_o` is 0 and `rd_data_o` is 8'h00.
- R2: Outside a busy period and outside the settling window, a read returns `array_data_i` as sampled with the strobe. The result appears one cycle after the strobe, with `rd_valid_o` high for exactly that cycle.
- R3: During a write (busy high, erase low), bit 7 of a read is the inverse of bit 7 of the captured last-loaded byte.
- R4: During a busy period, bit 6 alternates on each read: 1, 0, 1, and so on.
- R5: Each new busy period starts its bit-6 sequence at 1, whatever value the previous period ended on.
- R6: During a busy period, bits 5..0 of a read equal the parameter `FILL` (default 6'h15).
- R7: During an erase (busy high, erase high), bit 7 reads 0 and bit 6 alternates as in R4.
- R8: A settling window starts in the cycle busy falls and lasts `SETTLE_CYCLES` cycles (default 4, minimum 2). A read inside the window returns {array[7:6], FILL}. A read one cycle later returns the full array byte.
- R9: The last-loaded byte is captured on `load_i` only while busy is low. A load strobe during busy has no effect on bit 7.
- R10: Without a read strobe, `rd_valid_o` stays 0 and `rd_data_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy_i | input | 1 | Internal write or erase in progress |
| erase_i | input | 1 | Current busy period is a chip erase |
| load_i | input | 1 | Byte-load strobe from the host |
| load_data_i | input | 8 | Byte being loaded |
| rd_i | input | 1 | Read strobe |
| array_data_i | input | 8 | Stored data for the addressed location |
| rd_data_o | output | 8 | Read result |
| rd_valid_o | output | 1 | Result valid, one cycle after `rd_i` |

## Verification
The assertions check the following on every cycle:
- the valid pulse follows the strobe;
- the data is held when no strobe comes;
- array data passes through when the block is idle;
- bit 7 is inverted during writes and forced to 0 during erases;
- the flip state returns to 1 when idle;
- the settling window opens after busy falls.

Some behaviours need ordered stimulus, so only the bench scenarios show them:
- the exact 1, 0, 1 sequence of bit 6 across successive reads;
- the restart of that sequence in a new busy period;
- the length of the settling window down to its last cycle;
- a load strobe being ignored during busy.

// File: rtl/wsp_pkg.sv
package wsp_pkg;

  // Status byte returned while the block is busy.
  function automatic logic [7:0] busy_status(input logic erase,
                                             input logic last_b7,
                                             input logic flip,
                                             input logic [5:0] fill);
    logic b7;
    b7 = erase ? 1'b0 : ~last_b7;
    return {b7, flip, fill};
  endfunction

  // Byte returned inside the post-completion settling window.
  function automatic logic [7:0] settle_status(input logic [7:0] arr,
                                               input logic [5:0] fill);
    return {arr[7:6], fill};
  endfunction

endpackage

// File: rtl/wsp_last_latch.sv
module wsp_last_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy_i,
  input  logic       load_i,
  input  logic [7:0] load_data_i,
  output logic [7:0] last_o
);
  logic take;
  assign take = load_i & ~busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_o <= 8'hFF;
    else if (take) last_o <= load_data_i;
  end

  p_busy_load_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(last_o));
endmodule

// File: rtl/wsp_toggle_gen.sv
module wsp_toggle_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic rd_i,
  output logic flip_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flip_o <= 1'b1;
    else if (!busy_i) flip_o <= 1'b1;
    else if (rd_i)    flip_o <= ~flip_o;
  end

  p_idle_flip_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |=> flip_o);
  p_no_read_no_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !rd_i) |=> (flip_o == $past(flip_o)) || !$past(busy_i));
endmodule

// File: rtl/wsp_settle_timer.sv
module wsp_settle_timer #(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  output logic settling_o
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);

  logic          busy_q;
  logic          fall;
  logic [CW-1:0] cnt;

  assign fall       = busy_q & ~busy_i;
  assign settling_o = ~busy_i & (fall | (cnt != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt    <= '0;
    end else begin
      busy_q <= busy_i;
      if (busy_i)          cnt <= '0;
      else if (fall)       cnt <= CW'(SETTLE_CYCLES - 1);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
    end
  end

  p_window_opens_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> (busy_i || settling_o));
  p_no_settle_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_i) |=> (cnt == '0));
endmodule

// File: rtl/wsp_status_responder.sv
module wsp_status_responder #(
  parameter int         SETTLE_CYCLES = 4,
  parameter logic [5:0] FILL          = 6'h15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy_i,
  input  logic       erase_i,
  input  logic       load_i,
  input  logic [7:0] load_data_i,
  input  logic       rd_i,
  input  logic [7:0] array_data_i,
  output logic [7:0] rd_data_o,
  output logic       rd_valid_o
);
  import wsp_pkg::*;

  logic [7:0] last_byte;
  logic       flip;
  logic       settling;
  logic [7:0] status_nxt;

  wsp_last_latch u_last (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_i),
    .load_i(load_i), .load_data_i(load_data_i), .last_o(last_byte));

  wsp_toggle_gen u_flip (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .rd_i(rd_i), .flip_o(flip));

  wsp_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .settling_o(settling));

  always_comb begin
    if (busy_i)        status_nxt = busy_status(erase_i, last_byte[7], flip, FILL);
    else if (settling) status_nxt = settle_status(array_data_i, FILL);
    else               status_nxt = array_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_o  <= 8'h00;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_i;
      if (rd_i) rd_data_o <= status_nxt;
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> rd_valid_o);
  p_idle_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !busy_i && !settling) |=> rd_data_o == $past(array_data_i));
  p_write_bit7_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && busy_i && !erase_i) |=> rd_data_o[7] == ~$past(last_byte[7]));
  p_busy_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && busy_i) |=> rd_data_o[5:0] == FILL);
  p_erase_bit7_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && busy_i && erase_i) |=> !rd_data_o[7]);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> (!rd_valid_o && $stable(rd_data_o)));
endmodule

// File: tb/sim_wsp_status_responder.sv
module sim_wsp_status_responder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busy = 1'b0, erase = 1'b0, load = 1'b0, rd = 1'b0;
  logic [7:0] load_data = 8'h00, arr = 8'h00;
  logic [7:0] rd_data;
  logic rd_valid;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  typedef struct { logic [7:0] exp; string req; } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  wsp_status_responder u0 (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .erase_i(erase),
    .load_i(load), .load_data_i(load_data), .rd_i(rd),
    .array_data_i(arr), .rd_data_o(rd_data), .rd_valid_o(rd_valid));

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: one read per cycle, expected value pushed at the strobe.
  task automatic do_read(input logic [7:0] a, input logic [7:0] exp, input string req);
    arr = a;
    rd = 1'b1;
    sb.push_back('{exp, req});
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic do_load(input logic [7:0] d);
    load = 1'b1; load_data = d;
    @(negedge clk);
    load = 1'b0;
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (sb.size() == 0) check(1'b0, "R2", rd_data, 8'hxx);
      else begin
        item_t it;
        it = sb.pop_front();
        check(rd_data === it.exp, it.req, rd_data, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 8'h00, 8'h00);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    @(negedge clk);
    check(rd_valid === 1'b0, "R1", {7'd0, rd_valid}, 8'h00);
    check(rd_data === 8'h00, "R1", rd_data, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: idle pass-through, two patterns
    do_read(8'hA5, 8'hA5, "R2");
    do_read(8'h3C, 8'h3C, "R2");

    // R10: no strobe, output held, no valid
    held = 8'h3C;
    arr = 8'hFF;
    repeat (3) begin
      @(negedge clk);
      check(rd_valid === 1'b0 && rd_data === held, "R10", rd_data, held);
    end

    // Write busy: last byte bit7 = 1 -> bit7 reads 0 (R3), bit6 1,0,1 (R4), fill 15h (R6)
    do_load(8'h80);
    busy = 1'b1;
    @(negedge clk);
    do_read(8'h00, 8'h55, "R3");
    do_read(8'h00, 8'h15, "R4");
    do_read(8'h00, 8'h55, "R6");
    // R9: load during busy ignored
    do_load(8'h00);
    do_read(8'h00, 8'h15, "R9");

    // R8: settling window of 4 cycles, array C3h
    busy = 1'b0;
    do_read(8'hC3, 8'hD5, "R8");
    do_read(8'hC3, 8'hD5, "R8");
    do_read(8'hC3, 8'hD5, "R8");
    do_read(8'hC3, 8'hD5, "R8");
    do_read(8'hC3, 8'hC3, "R8");

    // R5: new busy period restarts flip at 1; last byte 00h -> bit7 reads 1
    do_load(8'h00);
    busy = 1'b1;
    @(negedge clk);
    do_read(8'h00, 8'hD5, "R5");
    busy = 1'b0;
    repeat (6) @(negedge clk);

    // R7: erase, bit7 = 0, bit6 toggles
    busy = 1'b1; erase = 1'b1;
    @(negedge clk);
    do_read(8'hFF, 8'h55, "R7");
    do_read(8'hFF, 8'h15, "R7");
    busy = 1'b0; erase = 1'b0;
    repeat (6) @(negedge clk);
    do_read(8'h5A, 8'h5A, "R2");

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R2", 8'(sb.size()), 8'h00);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule